// File: doc/BRIEF.md
# Shared pseudo-interrupt dispatch register

This block is a scheduling point that many processors and I/O devices share. Any requester asks for a software process to be run by posting that process's number on one of several write ports. The number then joins a pending set, in which each process holds at most one entry. A processor that is ready for new work asserts one of several read ports. One cycle later it receives the number of the highest-priority pending process, and that entry leaves the set. Each request is therefore handed to exactly one reader.

Every cycle, writes are applied before reads. The read ports are then served in fixed index order, lowest index first, and each granted port takes the best entry that remains. The pending set is tracked by a two-state machine. State `ST_EMPTY` means nothing is pending and `ST_HOLDING` means at least one entry waits. The *post* transition (`ST_EMPTY` to `ST_HOLDING`) occurs when entries survive a cycle's reads. The *drain* transition (`ST_HOLDING` to `ST_EMPTY`) occurs when the last entry is taken. Both states otherwise hold. The state is presented as the empty indication. Reset is synchronous and active high.

Top module: `pid_dispatch`

## Requirements
- R1: A write with `wr_en[w]=1` and process number `wr_id[w*IDW +: IDW]` makes that process pending from the next clock edge, so `empty` reads 0 after that edge.
- R2: Posting a number that is already pending, or posting it on two ports in one cycle, leaves one entry, and only one read returns it.
- R3: A granted read returns `rd_valid[k]=1` and the process number on `rd_id[k*IDW +: IDW]` in the cycle after `rd_en[k]` was sampled. The number is the largest one pending, and the entry is removed at that same edge.
- R4: A read that finds nothing pending, and every port that did not read, gives `rd_valid[k]=0` with `rd_id` slice 0.
- R5: Read ports that are active together are granted from index 0 upward. Each granted port gets a different process, in strictly descending number. Ports left over get the R4 response.
- R6: A write and a read in the same cycle act as if the write came first, so a just-posted number can be returned by that cycle's read if it is the largest.
- R7: While `rst=1` at a clock edge, every pending entry is cleared, `rd_valid` is 0 and `empty` is 1 after that edge, whatever the other inputs are.
- R8: `empty` is 1 exactly when no entry is pending after the last edge (state `ST_EMPTY`), and 0 in state `ST_HOLDING`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | NWR | Per-port post strobe |
| wr_id | input | NWR*IDW | Per-port process number to post, port w at bits w*IDW +: IDW |
| rd_en | input | NRD | Per-port take request |
| rd_valid | output | NRD | Per-port grant flag, registered |
| rd_id | output | NRD*IDW | Per-port granted process number, 0 when not granted |
| empty | output | 1 | No process pending |

## Verification
The bench builds the block with 16 process numbers, three write ports and three read ports. With so few numbers, random posts often collide with entries already pending, and three readers can drain the whole set within a few cycles. This brings duplicate merging, leftover-port empty responses and the drain transition into frequent reach. Directed phases first pin down exact values for the same-cycle write-then-read ordering and for a reset that arrives while ports are active.

// File: rtl/pid_pkg.sv
package pid_pkg;

    typedef enum logic {
        ST_EMPTY   = 1'b0,
        ST_HOLDING = 1'b1
    } pid_state_e;

endpackage

// File: rtl/pid_wr_merge.sv
module pid_wr_merge #(
    parameter int NPROC = 64,
    parameter int NWR   = 4,
    parameter int IDW   = 6
) (
    input  logic [NWR-1:0]     wr_en,
    input  logic [NWR*IDW-1:0] wr_id,
    output logic [NPROC-1:0]   post_mask
);

    // OR all posts into one mask; duplicates collapse to one bit
    always_comb begin
        post_mask = '0;
        for (int w = 0; w < NWR; w++) begin
            if (wr_en[w]) begin
                post_mask[wr_id[w*IDW +: IDW]] = 1'b1;
            end
        end
    end

endmodule

// File: rtl/pid_prio_pick.sv
module pid_prio_pick #(
    parameter int NPROC = 64,
    parameter int IDW   = 6
) (
    input  logic [NPROC-1:0] avail,
    input  logic             take,
    output logic             hit,
    output logic [IDW-1:0]   id,
    output logic [NPROC-1:0] remain
);

    // highest set bit wins: later iterations overwrite earlier ones
    always_comb begin
        hit = 1'b0;
        id  = '0;
        for (int p = 0; p < NPROC; p++) begin
            if (avail[p]) begin
                hit = 1'b1;
                id  = p[IDW-1:0];
            end
        end
    end

    always_comb begin
        remain = avail;
        if (take && hit) begin
            remain[id] = 1'b0;
        end
    end

endmodule

// File: rtl/pid_dispatch.sv
module pid_dispatch
    import pid_pkg::*;
#(
    parameter  int NPROC = 64,
    parameter  int NWR   = 4,
    parameter  int NRD   = 4,
    localparam int IDW   = $clog2(NPROC)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NWR-1:0]     wr_en,
    input  logic [NWR*IDW-1:0] wr_id,
    input  logic [NRD-1:0]     rd_en,
    output logic [NRD-1:0]     rd_valid,
    output logic [NRD*IDW-1:0] rd_id,
    output logic               empty
);

    pid_state_e       state;
    pid_state_e       state_nxt;
    logic [NPROC-1:0] pending;
    logic [NPROC-1:0] post_mask;
    logic [NPROC-1:0] avail [0:NRD];
    logic [NRD-1:0]   hit;
    logic [IDW-1:0]   pick_id [0:NRD-1];
    logic             past_ok;

    pid_wr_merge #(
        .NPROC (NPROC),
        .NWR   (NWR),
        .IDW   (IDW)
    ) u_merge (
        .wr_en     (wr_en),
        .wr_id     (wr_id),
        .post_mask (post_mask)
    );

    // writes land before any read looks at the set
    assign avail[0] = pending | post_mask;

    // chain of pickers, one per read port, in port order
    for (genvar k = 0; k < NRD; k++) begin : g_pick
        pid_prio_pick #(
            .NPROC (NPROC),
            .IDW   (IDW)
        ) u_pick (
            .avail  (avail[k]),
            .take   (rd_en[k]),
            .hit    (hit[k]),
            .id     (pick_id[k]),
            .remain (avail[k+1])
        );
    end

    // next state: post / drain / hold
    always_comb begin
        unique case (state)
            ST_EMPTY:   state_nxt = (|avail[NRD]) ? ST_HOLDING : ST_EMPTY;
            ST_HOLDING: state_nxt = (|avail[NRD]) ? ST_HOLDING : ST_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_EMPTY;
            pending <= '0;
        end else begin
            state   <= state_nxt;
            pending <= avail[NRD];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid <= '0;
            rd_id    <= '0;
        end else begin
            for (int k = 0; k < NRD; k++) begin
                rd_valid[k]           <= rd_en[k] && hit[k];
                rd_id[k*IDW +: IDW]   <= (rd_en[k] && hit[k]) ? pick_id[k] : '0;
            end
        end
    end

    assign empty = (state == ST_EMPTY);

    always_ff @(posedge clk) begin
        if (rst) past_ok <= 1'b0;
        else     past_ok <= 1'b1;
    end

    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (empty && rd_valid == '0)); // R7

    AST_EMPTY_TRACKS_SET: assert property (@(posedge clk) disable iff (rst)
        empty == (pending == '0)); // R8

    for (genvar k = 0; k < NRD; k++) begin : g_ast
        AST_IDLE_ID_ZERO: assert property (@(posedge clk) disable iff (rst)
            !rd_valid[k] |-> rd_id[k*IDW +: IDW] == '0); // R4

        AST_TAKEN_CLEARED: assert property (@(posedge clk) disable iff (rst)
            rd_valid[k] |-> !pending[rd_id[k*IDW +: IDW]]); // R3

        AST_GRANT_HAS_SOURCE: assert property (@(posedge clk) disable iff (rst)
            (past_ok && rd_valid[k]) |-> ($past(rd_en[k]) && ($past(!empty) || $past(|wr_en)))); // R6

        for (genvar j = 0; j < k; j++) begin : g_pair
            AST_PORT_DESCEND: assert property (@(posedge clk) disable iff (rst)
                (rd_valid[j] && rd_valid[k]) |-> rd_id[j*IDW +: IDW] > rd_id[k*IDW +: IDW]); // R5
        end
    end

endmodule

// File: tb/test_pid_dispatch.sv
module test_pid_dispatch;

    localparam int NPROC = 16;
    localparam int NWR   = 3;
    localparam int NRD   = 3;
    localparam int IDW   = $clog2(NPROC);

    logic               clk = 1'b0;
    logic               rst;
    logic [NWR-1:0]     wr_en;
    logic [NWR*IDW-1:0] wr_id;
    logic [NRD-1:0]     rd_en;
    logic [NRD-1:0]     rd_valid;
    logic [NRD*IDW-1:0] rd_id;
    logic               empty;

    int nchk = 0;
    int nfail = 0;

    bit mdl [NPROC];
    int exp_valid [NRD];
    int exp_id [NRD];
    int exp_empty;

    always #5 clk = ~clk;

    pid_dispatch #(
        .NPROC (NPROC),
        .NWR   (NWR),
        .NRD   (NRD)
    ) i_pid_dispatch (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_id    (wr_id),
        .rd_en    (rd_en),
        .rd_valid (rd_valid),
        .rd_id    (rd_id),
        .empty    (empty)
    );

    task automatic chk(string req, string what, int act, int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic idle();
        wr_en = '0;
        wr_id = '0;
        rd_en = '0;
    endtask

    task automatic post(int port, int id);
        wr_en[port] = 1'b1;
        wr_id[port*IDW +: IDW] = id[IDW-1:0];
    endtask

    function automatic int got_id(int r);
        return int'(rd_id[r*IDW +: IDW]);
    endfunction

    // behavioural reference: a set of flags, writes first, then ports in order
    task automatic model_step();
        if (rst) begin
            foreach (mdl[p]) mdl[p] = 1'b0;
            foreach (exp_valid[r]) begin
                exp_valid[r] = 0;
                exp_id[r] = 0;
            end
        end else begin
            for (int w = 0; w < NWR; w++)
                if (wr_en[w]) mdl[int'(wr_id[w*IDW +: IDW])] = 1'b1;
            for (int r = 0; r < NRD; r++) begin
                exp_valid[r] = 0;
                exp_id[r] = 0;
                if (rd_en[r]) begin
                    for (int p = NPROC-1; p >= 0; p--) begin
                        if (mdl[p]) begin
                            exp_valid[r] = 1;
                            exp_id[r] = p;
                            mdl[p] = 1'b0;
                            break;
                        end
                    end
                end
            end
        end
        exp_empty = 1;
        foreach (mdl[p]) if (mdl[p]) exp_empty = 0;
    endtask

    task automatic step(string req);
        @(posedge clk);
        model_step();
        @(negedge clk);
        chk("R8", "empty", int'(empty), exp_empty);
        for (int r = 0; r < NRD; r++) begin
            chk(req, $sformatf("valid[%0d]", r), int'(rd_valid[r]), exp_valid[r]);
            chk(req, $sformatf("id[%0d]", r), got_id(r), exp_id[r]);
        end
        idle();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nfail++;
        nchk++;
        $display("FAIL all watchdog: actual hung expected finish");
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

    initial begin
        idle();
        rst = 1'b1;
        step("R7");
        step("R7");
        rst = 1'b0;
        chk("R7", "reset empty", int'(empty), 1);
        chk("R7", "reset valid", int'(rd_valid), 0);

        // R1: a post makes the set non-empty
        post(1, 9);
        step("R1");
        chk("R1", "empty after post", int'(empty), 0);

        // R3: reads return the largest number, one at a time
        post(0, 3);
        post(2, 12);
        step("R3");
        rd_en[0] = 1'b1;
        step("R3");
        chk("R3", "first take", got_id(0), 12);
        rd_en[2] = 1'b1;
        step("R3");
        chk("R3", "second take", got_id(2), 9);
        rd_en[1] = 1'b1;
        step("R3");
        chk("R3", "third take", got_id(1), 3);
        chk("R8", "drained", int'(empty), 1);

        // R4: read with nothing pending
        rd_en[0] = 1'b1;
        rd_en[1] = 1'b1;
        step("R4");
        chk("R4", "empty read valid", int'(rd_valid), 0);
        chk("R4", "empty read id", int'(rd_id), 0);

        // R2: duplicates collapse
        post(0, 5);
        post(1, 5);
        step("R2");
        post(2, 5);
        step("R2");
        rd_en[0] = 1'b1;
        rd_en[1] = 1'b1;
        step("R2");
        chk("R2", "dup port0", got_id(0), 5);
        chk("R2", "dup port1 valid", int'(rd_valid[1]), 0);
        chk("R2", "dup drained", int'(empty), 1);

        // R5: three readers at once, descending, leftover empty
        post(0, 2);
        post(1, 7);
        post(2, 11);
        step("R5");
        post(0, 14);
        step("R5");
        rd_en = '1;
        step("R5");
        chk("R5", "port0", got_id(0), 14);
        chk("R5", "port1", got_id(1), 11);
        chk("R5", "port2", got_id(2), 7);
        rd_en = '1;
        step("R5");
        chk("R5", "last entry", got_id(0), 2);
        chk("R5", "leftover", int'(rd_valid[2:1]), 0);

        // R6: write then read in one cycle
        post(1, 10);
        rd_en[0] = 1'b1;
        step("R6");
        chk("R6", "same-cycle id", got_id(0), 10);
        chk("R6", "same-cycle empty", int'(empty), 1);
        post(0, 4);
        step("R6");
        post(2, 1);
        rd_en[1] = 1'b1;
        step("R6");
        chk("R6", "larger wins", got_id(1), 4);

        // R7: reset while ports are busy
        post(0, 13);
        post(1, 6);
        step("R7");
        rst = 1'b1;
        post(2, 8);
        rd_en = '1;
        step("R7");
        rst = 1'b0;
        chk("R7", "mid reset valid", int'(rd_valid), 0);
        chk("R7", "mid reset empty", int'(empty), 1);
        rd_en = '1;
        step("R7");
        chk("R7", "nothing survives", int'(rd_valid), 0);

        // random traffic against the reference model
        for (int c = 0; c < 4000; c++) begin
            for (int w = 0; w < NWR; w++)
                if ($urandom_range(0, 2) == 0) post(w, int'($urandom_range(0, NPROC-1)));
            for (int r = 0; r < NRD; r++)
                rd_en[r] = ($urandom_range(0, 2) == 0);
            rst = ($urandom_range(0, 299) == 0);
            step(rst ? "R7" : "R5");
            rst = 1'b0;
        end

        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

endmodule